// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block decides, every cycle, where the operands of a five-stage in-order 32-bit pipeline should come from. The register numbers that the execute-stage instruction reads are compared with the destination numbers carried by the instructions in the memory and writeback stages. A 2-bit select per ALU operand then tells the datapath to take the register-file value, the ALU result of the instruction one stage ahead, or the value being written back. A store sitting in the memory stage can also take its store data straight from the load that has just reached writeback. That memory-to-memory path lets a load followed directly by a store of the loaded value run without a stall.

When no path can deliver a value in time, the block raises an interlock. This happens when a load in execute produces a register that the decode-stage instruction needs as an ALU operand or base address. The fetch and decode registers then hold for one cycle and a bubble enters execute. Dependent back-to-back instructions therefore need no software-inserted NOPs. The unit is purely combinational and has no clock or reset. All inputs and outputs are plain control signals with no handshake, so back-pressure does not apply. The datapath muxes, the register file and branch handling live outside it.

Top module: `bypass_ctrl`

## Requirements
- R1: An ALU operand select (`sel_a` for `x_rs`, `sel_b` for `x_rt`) is 2'b10 when the memory-stage producer has `m_we`=1 and `m_load`=0, and its non-zero `m_rd` equals that source register.
- R2: An ALU operand select is 2'b01 when the writeback-stage producer has `w_we`=1 and its non-zero `w_rd` equals that source register, and R1 does not apply.
- R3: When both the memory-stage and the writeback-stage producers match a source, the select is 2'b10, because the younger producer wins.
- R4: Register 0 is never forwarded. A source or destination of 0 leaves the operand select at 2'b00 and the store select at 0.
- R5: A producer whose write enable is 0 never causes forwarding, even when its destination number matches.
- R6: An operand select is 2'b00 (register file) when no producer matches. The select value 2'b11 never appears.
- R7: `sel_st` is 1 exactly when `m_store`=1 and the writeback producer has `w_we`=1 and a non-zero `w_rd` equal to `m_rt`. Otherwise it is 0.
- R8: `hold_fetch`, `hold_decode` and `bubble_exec` are all 1 when the execute-stage instruction is a load (`x_load`=1, `x_we`=1, non-zero `x_rd`) and `x_rd` equals `d_rs` with `d_rs_used`=1, or equals `d_rt` with `d_rt_used`=1 and `d_is_store`=0.
- R9: A decode-stage store whose only match with the execute-stage load is its store-data register (`d_rt`, with `d_is_store`=1) does not stall.
- R10: A load in the memory stage (`m_load`=1) is never selected through the 2'b10 path.
- R11: No stall is raised when the execute-stage instruction is not a write-enabled load, when its destination is 0, or when the decode instruction does not read the matching register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_rs | input | 5 | First source register of the decode-stage instruction |
| d_rt | input | 5 | Second source register of the decode-stage instruction |
| d_rs_used | input | 1 | Decode instruction reads d_rs |
| d_rt_used | input | 1 | Decode instruction reads d_rt |
| d_is_store | input | 1 | Decode instruction is a store, so d_rt is store data only |
| x_rs | input | 5 | First source register of the execute-stage instruction |
| x_rt | input | 5 | Second source register of the execute-stage instruction |
| x_rd | input | 5 | Destination register of the execute-stage instruction |
| x_we | input | 1 | Execute-stage instruction writes a register |
| x_load | input | 1 | Execute-stage instruction is a load |
| m_rd | input | 5 | Destination register of the memory-stage instruction |
| m_rt | input | 5 | Store-data register of the memory-stage instruction |
| m_we | input | 1 | Memory-stage instruction writes a register |
| m_load | input | 1 | Memory-stage instruction is a load |
| m_store | input | 1 | Memory-stage instruction is a store |
| w_rd | input | 5 | Destination register of the writeback-stage instruction |
| w_we | input | 1 | Writeback-stage instruction writes a register |
| sel_a | output | 2 | Operand A select: 00 register file, 10 memory-stage ALU result, 01 writeback value |
| sel_b | output | 2 | Operand B select, same encoding as sel_a |
| sel_st | output | 1 | Store data in memory stage: 0 pipeline value, 1 writeback value |
| hold_fetch | output | 1 | Hold the program counter and fetch register |
| hold_decode | output | 1 | Hold the decode register |
| bubble_exec | output | 1 | Insert a bubble into the execute register |

## Verification
The bench drives the cases where a wrong select passes silently through a datapath. It uses sources matched by both producers at once; a design with the priority reversed would feed the older writeback value. It uses register 0 as a destination, where a missing zero guard would forward a discarded result. It uses matching producers with write enable low, and loads sitting in the memory stage, which would otherwise send an address into the ALU. On the interlock side it separates a load followed by an ALU use, which must stall exactly while the pair is adjacent, from a load followed by a store of the loaded register, which must flow on. A design that stalled the latter would lose the memory-to-memory benefit, and one that skipped the former would read a stale operand.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    OPSEL_RF  = 2'b00,
    OPSEL_WB  = 2'b01,
    OPSEL_MEM = 2'b10
  } opsel_e;
endpackage

// File: rtl/bypass_src_sel.sv
module bypass_src_sel
  import bypass_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] src,
  input  logic           m_we,
  input  logic           m_load,
  input  logic [RAW-1:0] m_rd,
  input  logic           w_we,
  input  logic [RAW-1:0] w_rd,
  output opsel_e         sel
);
  logic mem_hit, wb_hit;

  // The memory-stage value is an ALU result only when the instruction is not a load.
  assign mem_hit = m_we && !m_load && (m_rd != '0) && (m_rd == src);
  assign wb_hit  = w_we && (w_rd != '0) && (w_rd == src);

  always_comb begin
    if (mem_hit)     sel = OPSEL_MEM;
    else if (wb_hit) sel = OPSEL_WB;
    else             sel = OPSEL_RF;
  end
endmodule

// File: rtl/bypass_store_sel.sv
module bypass_store_sel #(
  parameter int RAW = 5
) (
  input  logic           m_store,
  input  logic [RAW-1:0] m_rt,
  input  logic           w_we,
  input  logic [RAW-1:0] w_rd,
  output logic           take_wb
);
  assign take_wb = m_store && w_we && (w_rd != '0) && (w_rd == m_rt);
endmodule

// File: rtl/bypass_load_use.sv
module bypass_load_use #(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] d_rs,
  input  logic [RAW-1:0] d_rt,
  input  logic           d_rs_used,
  input  logic           d_rt_used,
  input  logic           d_is_store,
  input  logic [RAW-1:0] x_rd,
  input  logic           x_we,
  input  logic           x_load,
  output logic           stall
);
  logic live_load, rs_dep, rt_dep;

  assign live_load = x_load && x_we && (x_rd != '0);
  assign rs_dep    = d_rs_used && (d_rs == x_rd);
  // Store data can be caught later on the memory-to-memory path.
  assign rt_dep    = d_rt_used && !d_is_store && (d_rt == x_rd);
  assign stall     = live_load && (rs_dep || rt_dep);
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int RAW = 5
) (
  input  logic [RAW-1:0] d_rs,
  input  logic [RAW-1:0] d_rt,
  input  logic           d_rs_used,
  input  logic           d_rt_used,
  input  logic           d_is_store,
  input  logic [RAW-1:0] x_rs,
  input  logic [RAW-1:0] x_rt,
  input  logic [RAW-1:0] x_rd,
  input  logic           x_we,
  input  logic           x_load,
  input  logic [RAW-1:0] m_rd,
  input  logic [RAW-1:0] m_rt,
  input  logic           m_we,
  input  logic           m_load,
  input  logic           m_store,
  input  logic [RAW-1:0] w_rd,
  input  logic           w_we,
  output logic [1:0]     sel_a,
  output logic [1:0]     sel_b,
  output logic           sel_st,
  output logic           hold_fetch,
  output logic           hold_decode,
  output logic           bubble_exec
);
  localparam int NOPS = 2;

  logic [RAW-1:0] srcs [NOPS];
  opsel_e         sels [NOPS];
  logic           stall;

  assign srcs[0] = x_rs;
  assign srcs[1] = x_rt;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    bypass_src_sel #(.RAW(RAW)) u_sel (
      .src   (srcs[g]),
      .m_we  (m_we),
      .m_load(m_load),
      .m_rd  (m_rd),
      .w_we  (w_we),
      .w_rd  (w_rd),
      .sel   (sels[g])
    );
  end

  bypass_store_sel #(.RAW(RAW)) u_st (
    .m_store(m_store),
    .m_rt   (m_rt),
    .w_we   (w_we),
    .w_rd   (w_rd),
    .take_wb(sel_st)
  );

  bypass_load_use #(.RAW(RAW)) u_lu (
    .d_rs      (d_rs),
    .d_rt      (d_rt),
    .d_rs_used (d_rs_used),
    .d_rt_used (d_rt_used),
    .d_is_store(d_is_store),
    .x_rd      (x_rd),
    .x_we      (x_we),
    .x_load    (x_load),
    .stall     (stall)
  );

  assign sel_a       = sels[0];
  assign sel_b       = sels[1];
  assign hold_fetch  = stall;
  assign hold_decode = stall;
  assign bubble_exec = stall;
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
  parameter int RAW = 5
) (
  input logic [RAW-1:0] d_rs,
  input logic [RAW-1:0] d_rt,
  input logic           d_rs_used,
  input logic           d_rt_used,
  input logic           d_is_store,
  input logic [RAW-1:0] x_rs,
  input logic [RAW-1:0] x_rt,
  input logic [RAW-1:0] x_rd,
  input logic           x_we,
  input logic           x_load,
  input logic [RAW-1:0] m_rd,
  input logic [RAW-1:0] m_rt,
  input logic           m_we,
  input logic           m_load,
  input logic           m_store,
  input logic [RAW-1:0] w_rd,
  input logic           w_we,
  input logic [1:0]     sel_a,
  input logic [1:0]     sel_b,
  input logic           sel_st,
  input logic           hold_fetch,
  input logic           hold_decode,
  input logic           bubble_exec
);
  always_comb begin
    AST_SEL_CODE_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11) else $error("illegal select code"); // R6
    AST_ZERO_SRC_A: assert (x_rs != '0 || sel_a == 2'b00) else $error("r0 forwarded on A"); // R4
    AST_ZERO_SRC_B: assert (x_rt != '0 || sel_b == 2'b00) else $error("r0 forwarded on B"); // R4
    AST_NO_WE_NO_FWD: assert (m_we || w_we || (sel_a == 2'b00 && sel_b == 2'b00 && !sel_st)) else $error("forward without write enable"); // R5
    AST_LOAD_NOT_EXEX: assert (!m_load || (sel_a != 2'b10 && sel_b != 2'b10)) else $error("load used on ALU path"); // R10
    AST_BOTH_MATCH_YOUNGER: assert (!(m_we && !m_load && m_rd != '0 && m_rd == x_rs && w_we && w_rd == x_rs) || sel_a == 2'b10) else $error("priority"); // R3
    AST_STORE_SEL_NEEDS_STORE: assert (m_store || !sel_st) else $error("store select without store"); // R7
    AST_STALL_SIGNALS_AGREE: assert (hold_fetch == hold_decode && hold_decode == bubble_exec) else $error("stall outputs disagree"); // R8
    AST_NO_STALL_WITHOUT_LOAD: assert ((x_load && x_we && x_rd != '0) || !hold_fetch) else $error("stall without load"); // R11
  end
endmodule

bind bypass_ctrl bypass_ctrl_chk #(.RAW(RAW)) u_chk (.*);

// File: tb/sim_bypass_ctrl.sv
module sim_bypass_ctrl;
  localparam int RAW = 5;

  typedef struct packed {
    logic [RAW-1:0] d_rs, d_rt;
    logic d_rs_used, d_rt_used, d_is_store;
    logic [RAW-1:0] x_rs, x_rt, x_rd;
    logic x_we, x_load;
    logic [RAW-1:0] m_rd, m_rt;
    logic m_we, m_load, m_store;
    logic [RAW-1:0] w_rd;
    logic w_we;
  } vec_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  vec_t v;
  logic [1:0] sel_a, sel_b;
  logic sel_st, hold_fetch, hold_decode, bubble_exec;

  bypass_ctrl #(.RAW(RAW)) u0 (
    .d_rs(v.d_rs), .d_rt(v.d_rt), .d_rs_used(v.d_rs_used), .d_rt_used(v.d_rt_used),
    .d_is_store(v.d_is_store), .x_rs(v.x_rs), .x_rt(v.x_rt), .x_rd(v.x_rd),
    .x_we(v.x_we), .x_load(v.x_load), .m_rd(v.m_rd), .m_rt(v.m_rt), .m_we(v.m_we),
    .m_load(v.m_load), .m_store(v.m_store), .w_rd(v.w_rd), .w_we(v.w_we),
    .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st), .hold_fetch(hold_fetch),
    .hold_decode(hold_decode), .bubble_exec(bubble_exec)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string tag_q [$];

  function automatic logic [1:0] want_sel(vec_t t, logic [RAW-1:0] s);
    if (t.m_we && !t.m_load && t.m_rd != 0 && t.m_rd == s) return 2'b10; // R1 R3
    if (t.w_we && t.w_rd != 0 && t.w_rd == s) return 2'b01;             // R2
    return 2'b00;                                                       // R6
  endfunction

  function automatic logic [7:0] model(vec_t t);
    logic st, stl;
    st  = t.m_store && t.w_we && t.w_rd != 0 && t.w_rd == t.m_rt;       // R7
    stl = t.x_load && t.x_we && t.x_rd != 0 &&
          ((t.d_rs_used && t.d_rs == t.x_rd) ||
           (t.d_rt_used && !t.d_is_store && t.d_rt == t.x_rd));         // R8 R9
    return {want_sel(t, t.x_rs), want_sel(t, t.x_rt), st, stl, stl, stl};
  endfunction

  task automatic apply(input vec_t t, input string tag);
    @(posedge clk);
    v = t;
    exp_q.push_back(model(t));
    tag_q.push_back(tag);
  endtask

  // Monitor: compares at the falling edge, half a cycle after inputs change.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [7:0] e, a;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        a  = {sel_a, sel_b, sel_st, hold_fetch, hold_decode, bubble_exec};
        n_vec++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", tg, a, e);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t t;
    v = '0;
    t = '0;
    apply(t, "R6 idle all-zero");

    t = '0; t.x_rs = 5'd3; t.m_rd = 5'd3; t.m_we = 1'b1;
    apply(t, "R1 mem-stage ALU to operand A");
    t = '0; t.x_rt = 5'd9; t.m_rd = 5'd9; t.m_we = 1'b1;
    apply(t, "R1 mem-stage ALU to operand B");
    t = '0; t.x_rs = 5'd7; t.w_rd = 5'd7; t.w_we = 1'b1;
    apply(t, "R2 writeback to operand A");
    t = '0; t.x_rt = 5'd31; t.w_rd = 5'd31; t.w_we = 1'b1;
    apply(t, "R2 writeback to operand B");
    t = '0; t.x_rs = 5'd4; t.x_rt = 5'd4; t.m_rd = 5'd4; t.m_we = 1'b1; t.w_rd = 5'd4; t.w_we = 1'b1;
    apply(t, "R3 both producers match");
    t = '0; t.m_we = 1'b1; t.w_we = 1'b1; t.m_store = 1'b1;
    apply(t, "R4 register 0 everywhere");
    t = '0; t.x_rs = 5'd6; t.m_rd = 5'd6; t.w_rd = 5'd6;
    apply(t, "R5 write enables low");
    t = '0; t.m_store = 1'b1; t.m_rt = 5'd6; t.w_rd = 5'd6;
    apply(t, "R5 store select with w_we low");
    t = '0; t.x_rs = 5'd2; t.m_rd = 5'd5; t.m_we = 1'b1; t.w_rd = 5'd8; t.w_we = 1'b1;
    apply(t, "R6 no match");
    t = '0; t.m_store = 1'b1; t.m_rt = 5'd12; t.w_rd = 5'd12; t.w_we = 1'b1;
    apply(t, "R7 memory-to-memory store data");
    t = '0; t.m_store = 1'b0; t.m_rt = 5'd12; t.w_rd = 5'd12; t.w_we = 1'b1;
    apply(t, "R7 not a store");
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.x_rd = 5'd10; t.d_rs = 5'd10; t.d_rs_used = 1'b1;
    apply(t, "R8 load-use on rs");
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.x_rd = 5'd11; t.d_rt = 5'd11; t.d_rt_used = 1'b1;
    apply(t, "R8 load-use on rt");
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.x_rd = 5'd11; t.d_rt = 5'd11; t.d_rt_used = 1'b1; t.d_is_store = 1'b1;
    apply(t, "R9 load then store of loaded value");
    t.d_rs = 5'd11; t.d_rs_used = 1'b1;
    apply(t, "R8 store base depends on load");
    t = '0; t.x_rs = 5'd13; t.x_rt = 5'd13; t.m_rd = 5'd13; t.m_we = 1'b1; t.m_load = 1'b1;
    apply(t, "R10 load in memory stage");
    t.w_rd = 5'd13; t.w_we = 1'b1;
    apply(t, "R10 mem load skipped, writeback used");
    t = '0; t.x_we = 1'b1; t.x_rd = 5'd10; t.d_rs = 5'd10; t.d_rs_used = 1'b1;
    apply(t, "R11 ALU producer no stall");
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.d_rs_used = 1'b1; t.d_rt_used = 1'b1;
    apply(t, "R11 load to r0 no stall");
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.x_rd = 5'd14; t.d_rs = 5'd14; t.d_rt = 5'd14;
    apply(t, "R11 source not read");

    // Load-use sequence: stall during adjacency, none once the load moves on.
    t = '0; t.x_load = 1'b1; t.x_we = 1'b1; t.x_rd = 5'd20; t.d_rs = 5'd20; t.d_rs_used = 1'b1;
    apply(t, "R8 sequence stall cycle");
    t = '0; t.x_rs = 5'd20; t.m_rd = 5'd0; t.m_we = 1'b0; t.w_rd = 5'd20; t.w_we = 1'b1;
    apply(t, "R2 sequence after bubble");

    for (int i = 0; i < 600; i++) begin
      t = vec_t'({$urandom, $urandom, $urandom});
      // Narrow register numbers so matches are frequent.
      t.d_rs = t.d_rs & 5'd3; t.d_rt = t.d_rt & 5'd3;
      t.x_rs = t.x_rs & 5'd3; t.x_rt = t.x_rt & 5'd3; t.x_rd = t.x_rd & 5'd3;
      t.m_rd = t.m_rd & 5'd3; t.m_rt = t.m_rt & 5'd3; t.w_rd = t.w_rd & 5'd3;
      apply(t, "RAND mix");
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule